// File: doc/BRIEF.md
# Byte/Word Load-Store Data Aligner

This unit sits between a core register file and a 32-bit memory data bus. On a load it takes the word returned by memory and positions it for the destination register. A byte load picks one lane, chosen by the two low address bits and the endianness pin, and zero-extends it. A word load whose address is not word aligned is rotated, so that the addressed byte sits at the register's natural end. On a store it forms the bus word from the source register. A byte store copies the low byte into every lane, so that whichever lane memory enables receives the right value. A word store passes the register through unchanged. Byte-enable generation is left to the memory system.

Each request carries the offset, the byte/word flag, the read data bus word and the store register value. Requests enter through a valid/ready input and leave through a valid/ready output after one register stage. A request is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output stays frozen and no new request is taken. `big_endian` is a plain configuration pin that is sampled with each accepted request.

Top module: `lsa_aligner`

## Requirements
- R1: With `big_endian`=0, a byte load at offset k (0..3) returns bus bits [8k+7:8k] in `out_load_data[7:0]`.
- R2: With `big_endian`=1, a byte load at offset k returns bus bits [31-8k:24-8k]: offset 0 selects [31:24] and offset 3 selects [7:0].
- R3: A byte load returns zero in `out_load_data[31:8]`.
- R4: With `big_endian`=0, a word load at offset k returns the bus word rotated right by 8k bits. Offsets 0 and 2 therefore leave the addressed halfword in bits [15:0].
- R5: With `big_endian`=1, a word load at offset k returns the bus word rotated left by 8k bits. In both modes an aligned word load (offset 0) returns the bus word unchanged.
- R6: A byte store drives the source's bits [7:0] into all four byte lanes of `out_store_data`, whatever the offset and endianness.
- R7: A word store drives the source value unchanged, whatever the offset and endianness.
- R8: A request accepted at a clock edge appears on the outputs with `out_valid`=1 right after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid`=1 and `out_ready`=0, the outputs stay stable and `out_valid` stays high.
- R9: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Lane order: 0 little, 1 big |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_byte | input | 1 | 1 byte transfer, 0 word transfer |
| in_ofs | input | 2 | Address bits [1:0] |
| in_rdata | input | 32 | Word from memory read bus |
| in_sdata | input | 32 | Store source register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_load_data | output | 32 | Value for the destination register |
| out_store_data | output | 32 | Value for the memory write bus |

## Verification
The bench builds the block with its default 32-bit word and 8-bit lanes, which gives four lanes and a two-bit offset. At this size every offset can be tried for byte loads, word loads and byte stores in both lane orders, using bus words whose lanes all differ. A second bus pattern confirms that the result follows the data and not fixed lanes. The default size also makes the stall case cheap to reach: a held result is checked against a second request that waits behind it.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic {
    LSA_LITTLE = 1'b0,
    LSA_BIG    = 1'b1
  } lsa_endian_e;

  typedef enum logic {
    LSA_ROT_RIGHT = 1'b0,
    LSA_ROT_LEFT  = 1'b1
  } lsa_rot_e;
endpackage

// File: rtl/lsa_lane_pick.sv
module lsa_lane_pick #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFS_W-1:0]  lane_i,
  output logic [DATA_W-1:0] data_o
);
  // One lane chosen, placed at the bottom, upper bits cleared.
  always_comb begin
    data_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_i == OFS_W'(i)) data_o[LANE_W-1:0] = data_i[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/lsa_rotator.sv
module lsa_rotator
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFS_W-1:0]  amt_i,
  input  lsa_rot_e          dir_i,
  output logic [DATA_W-1:0] data_o
);
  // Rotation in whole lanes; the lane index wraps modulo LANES.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFS_W-1:0]  src;
    logic [LANE_W-1:0] lane;
    assign src = (dir_i == LSA_ROT_LEFT) ? (OFS_W'(k) - amt_i) : (OFS_W'(k) + amt_i);
    always_comb begin
      lane = '0;
      for (int i = 0; i < LANES; i++) begin
        if (src == OFS_W'(i)) lane = data_i[i*LANE_W +: LANE_W];
      end
    end
    assign data_o[k*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/lsa_store_fmt.sv
module lsa_store_fmt #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] repl;
  for (genvar k = 0; k < LANES; k++) begin : g_rep
    assign repl[k*LANE_W +: LANE_W] = src_i[LANE_W-1:0];
  end
  assign data_o = byte_i ? repl : src_i;
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_byte,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic [DATA_W-1:0] in_rdata,
  input  logic [DATA_W-1:0] in_sdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_load_data,
  output logic [DATA_W-1:0] out_store_data
);
  lsa_endian_e       endian;
  logic [OFS_W-1:0]  lane_sel;
  logic [DATA_W-1:0] byte_val;
  logic [DATA_W-1:0] word_val;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] store_val;
  lsa_rot_e          rot_dir;
  logic              accept;
  logic              byte_q;

  assign endian   = lsa_endian_e'(big_endian);
  // Big-endian counts lanes from the top of the word.
  assign lane_sel = (endian == LSA_BIG) ? (OFS_W'(LANES - 1) - in_ofs) : in_ofs;
  assign rot_dir  = (endian == LSA_BIG) ? LSA_ROT_LEFT : LSA_ROT_RIGHT;

  lsa_lane_pick #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_pick (
    .data_i (in_rdata),
    .lane_i (lane_sel),
    .data_o (byte_val)
  );

  lsa_rotator #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rot (
    .data_i (in_rdata),
    .amt_i  (in_ofs),
    .dir_i  (rot_dir),
    .data_o (word_val)
  );

  lsa_store_fmt #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
    .src_i  (in_sdata),
    .byte_i (in_byte),
    .data_o (store_val)
  );

  assign load_val = in_byte ? byte_val : word_val;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      byte_q         <= 1'b0;
      out_load_data  <= '0;
      out_store_data <= '0;
    end else if (accept) begin
      out_valid      <= 1'b1;
      byte_q         <= in_byte;
      out_load_data  <= load_val;
      out_store_data <= store_val;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_load_data) && $stable(out_store_data)));

  p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && byte_q) |-> (out_load_data[DATA_W-1:LANE_W] == '0));

  p_lane_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && byte_q) |-> (out_store_data == {LANES{out_store_data[LANE_W-1:0]}}));

  p_aligned_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_byte && in_ofs == '0) |=> (out_load_data == $past(in_rdata)));
endmodule

// File: tb/sim_lsa_aligner.sv
`timescale 1ns/1ps
module sim_lsa_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_byte = 1'b0;
  logic [1:0]  in_ofs = 2'd0;
  logic [31:0] in_rdata = '0;
  logic [31:0] in_sdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_load_data;
  logic [31:0] out_store_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lsa_aligner u0 (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .in_ofs(in_ofs), .in_rdata(in_rdata), .in_sdata(in_sdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_load_data(out_load_data), .out_store_data(out_store_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge, let it be taken, look at the next falling edge.
  task automatic send(input logic be, input logic byt, input logic [1:0] ofs,
                      input logic [31:0] rd, input logic [31:0] sd);
    @(negedge clk);
    big_endian = be; in_byte = byt; in_ofs = ofs;
    in_rdata = rd; in_sdata = sd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] rot_r(input logic [31:0] w, input int k);
    logic [63:0] d = {w, w} >> (8 * k);
    return d[31:0];
  endfunction

  function automatic logic [31:0] rot_l(input logic [31:0] w, input int k);
    logic [63:0] d = {w, w} << (8 * k);
    return d[63:32];
  endfunction

  task automatic t_reset;
    #1;
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_byte_le(input logic [31:0] rd);
    for (int k = 0; k < 4; k++) begin
      send(1'b0, 1'b1, 2'(k), rd, 32'h0);
      chk("R8 valid", {31'd0, out_valid}, 32'd1);
      chk("R1 lane", {24'd0, out_load_data[7:0]}, {24'd0, rd[8*k +: 8]});
      chk("R3 zext", out_load_data & 32'hFFFF_FF00, 32'd0);
    end
  endtask

  task automatic t_byte_be(input logic [31:0] rd);
    for (int k = 0; k < 4; k++) begin
      send(1'b1, 1'b1, 2'(k), rd, 32'h0);
      chk("R2 lane", out_load_data, {24'd0, rd[8*(3-k) +: 8]});
    end
  endtask

  task automatic t_word_le(input logic [31:0] rd);
    for (int k = 0; k < 4; k++) begin
      send(1'b0, 1'b0, 2'(k), rd, 32'h0);
      chk("R4 rotate", out_load_data, rot_r(rd, k));
      if (k == 2) chk("R4 halfword", {16'd0, out_load_data[15:0]}, {16'd0, rd[31:16]});
    end
  endtask

  task automatic t_word_be(input logic [31:0] rd);
    for (int k = 0; k < 4; k++) begin
      send(1'b1, 1'b0, 2'(k), rd, 32'h0);
      chk("R5 rotate", out_load_data, rot_l(rd, k));
    end
  endtask

  task automatic t_store(input logic [31:0] sd);
    for (int e = 0; e < 2; e++) begin
      for (int k = 0; k < 4; k++) begin
        send(1'(e), 1'b1, 2'(k), 32'h0, sd);
        chk("R6 replicate", out_store_data, {4{sd[7:0]}});
        send(1'(e), 1'b0, 2'(k), 32'h0, sd);
        chk("R7 word store", out_store_data, sd);
      end
    end
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    send(1'b0, 1'b0, 2'd1, 32'h1122_3344, 32'h5566_7788);
    big_endian = 1'b0; in_byte = 1'b1; in_ofs = 2'd0;
    in_rdata = 32'hCAFE_F00D; in_sdata = 32'h0000_00AB; in_valid = 1'b1;
    #0;
    chk("R8 stalled ready", {31'd0, in_ready}, 32'd0);
    @(negedge clk); @(negedge clk);
    chk("R8 hold valid", {31'd0, out_valid}, 32'd1);
    chk("R8 hold load", out_load_data, 32'h4411_2233);
    chk("R8 hold store", out_store_data, 32'h5566_7788);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 next load", out_load_data, 32'h0000_000D);
    chk("R6 next store", out_store_data, 32'hABAB_ABAB);
    @(negedge clk);
    chk("R8 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_byte_le(32'hA1B2_C3D4);
    t_byte_le(32'h0F1E_2D3C);
    t_byte_be(32'hA1B2_C3D4);
    t_byte_be(32'h0F1E_2D3C);
    t_word_le(32'hA1B2_C3D4);
    t_word_be(32'hA1B2_C3D4);
    t_word_be(32'h0F1E_2D3C);
    t_store(32'h1234_56E7);
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule